// File: doc/BRIEF.md
# Multi-Step Carry-Feedback Sequence Generator

This block is a Galois-form feedback-with-carry shift register. Where an ordinary linear register would XOR the feedback bit into a tapped cell, this one adds it with carry. The register has `M` main cells, x0 to x(M-1), and one carry flip-flop at each tapped cell. On every enabled clock it advances `D` single steps and presents `D` consecutive sequence bits at once. This raises throughput by a factor of `D` without adding any storage.

The `D` steps are unrolled in combinational logic. Each tapped cell therefore gets a chain of `D` full adders, and its carry ripples from one sub-step to the next within the cycle. The tap positions come from a connection integer q chosen outside the block. The taps are the bits of (q-1)/2 below the top cell. When q is an odd prime power and 2 has order φ(q) modulo q, the output reaches the maximal period φ(q). The defaults are a 14-cell register with q = 18433 (one tap, at cell 10) and `D = 8`.

Top module: `fcsr_mstep_gen`

## Requirements
- R1: After reset, the main cells hold `RESET_SEED` and every carry is zero. With `en` low, `bits_out` shows the `D` bits that this state emits.
- R2: `bits_out[k]` is the bit emitted by the k-th single step from the current state, counting from k = 0. The emitted bit of a step is x0 before that step, so bit 0 is the first bit in sequence order.
- R3: On a clock edge with `en` high and `load` low, the state (main and carry cells) advances exactly `D` single steps.
- R4: On a clock edge with `en` and `load` both low, the main and carry state is unchanged.
- R5: On a clock edge with `load` high, the main cells take `seed_main` and each tapped carry takes the matching bit of `seed_carry`. This holds whatever the value of `en`.
- R6: Bits of `seed_carry` at positions where `CARRY_TAPS` is 0 have no effect. Those carries stay zero.
- R7: A single step works as follows. Let f = x0. For each i < M-1 with `CARRY_TAPS[i]` = 1, form the sum x(i+1) + f + c(i); x(i) takes the sum mod 2 and c(i) takes the sum div 2. For each untapped i < M-1, x(i) takes x(i+1). The top cell x(M-1) takes f.
- R8: After an advancing edge, the top cell holds the last bit of the word emitted on that edge, `bits_out[D-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Load seed into main and carry cells (wins over `en`) |
| seed_main | input | M | Seed for main cells x0..x(M-1), bit i to x(i) |
| seed_carry | input | M-1 | Seed for carries, bit i to c(i) where tapped |
| en | input | 1 | Advance D steps this clock |
| bits_out | output | D | Next D sequence bits, earliest in bit 0 |

## Verification
The bench drives several register sizes, tap sets and step counts from D = 1 up to D = 8. That range includes D equal to M, where the carry of a tapped cell is reused across every cell position within a single cycle. Carry seeds with ones at untapped positions expose a design that stores or adds them, because its sequence diverges from the reference after the load. A load asserted together with `en` catches a design that gives the advance priority. A dropped or mis-chained carry between sub-steps shows as a wrong bit late in the word, and only once carries are nonzero. A design with reversed bit order fails on the very first compared word.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

  typedef struct packed {
    logic co;
    logic s;
  } fa_t;

  function automatic fa_t full_add(input logic a, input logic b, input logic ci);
    fa_t r;
    r.s  = a ^ b ^ ci;
    r.co = (a & b) | (a & ci) | (b & ci);
    return r;
  endfunction

endpackage

// File: rtl/fcsr_step.sv
// One single step of the Galois carry register, purely combinational.
module fcsr_step #(
  parameter int M = 14,
  parameter logic [M-2:0] CARRY_TAPS = 13'h0400
) (
  input  logic [M-1:0] x,
  input  logic [M-2:0] c,
  output logic [M-1:0] x_n,
  output logic [M-2:0] c_n,
  output logic         fb
);
  import fcsr_pkg::*;

  assign fb       = x[0];
  assign x_n[M-1] = x[0];

  for (genvar i = 0; i < M-1; i++) begin : g_cell
    if (CARRY_TAPS[i]) begin : g_tap
      fa_t r;
      assign r      = full_add(x[i+1], x[0], c[i]);
      assign x_n[i] = r.s;
      assign c_n[i] = r.co;
    end else begin : g_plain
      logic unused_c;
      assign unused_c = c[i];
      assign x_n[i]   = x[i+1];
      assign c_n[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/fcsr_unroll.sv
// D chained steps; each tap's carry ripples through D full adders.
module fcsr_unroll #(
  parameter int M = 14,
  parameter int D = 8,
  parameter logic [M-2:0] CARRY_TAPS = 13'h0400
) (
  input  logic [M-1:0] x_in,
  input  logic [M-2:0] c_in,
  output logic [M-1:0] x_out,
  output logic [M-2:0] c_out,
  output logic [D-1:0] bits
);
  logic [D:0][M-1:0] xs;
  logic [D:0][M-2:0] cs;

  assign xs[0] = x_in;
  assign cs[0] = c_in;

  for (genvar k = 0; k < D; k++) begin : g_sub
    fcsr_step #(.M(M), .CARRY_TAPS(CARRY_TAPS)) u_step (
      .x   (xs[k]),
      .c   (cs[k]),
      .x_n (xs[k+1]),
      .c_n (cs[k+1]),
      .fb  (bits[k])
    );
  end

  assign x_out = xs[D];
  assign c_out = cs[D];
endmodule

// File: rtl/fcsr_mstep_gen.sv
module fcsr_mstep_gen #(
  parameter int M = 14,
  parameter int D = 8,
  parameter logic [M-2:0] CARRY_TAPS = 13'h0400,
  parameter logic [M-1:0] RESET_SEED = 14'h0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [M-1:0] seed_main,
  input  logic [M-2:0] seed_carry,
  input  logic         en,
  output logic [D-1:0] bits_out
);
  localparam int CW = M - 1;

  // reset synchronizer: async assert, sync release
  logic [1:0] rs_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ok = rs_q[1];

  logic [M-1:0]  main_q, main_d, main_adv;
  logic [CW-1:0] carry_q, carry_d, carry_adv;

  fcsr_unroll #(.M(M), .D(D), .CARRY_TAPS(CARRY_TAPS)) u_unroll (
    .x_in  (main_q),
    .c_in  (carry_q),
    .x_out (main_adv),
    .c_out (carry_adv),
    .bits  (bits_out)
  );

  // next state
  always_comb begin
    if (load) begin
      main_d  = seed_main;
      carry_d = seed_carry;
    end else if (en) begin
      main_d  = main_adv;
      carry_d = carry_adv;
    end else begin
      main_d  = main_q;
      carry_d = carry_q;
    end
  end

  // main cells
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) main_q <= RESET_SEED;
    else         main_q <= main_d;
  end

  // carry cells exist only at taps
  for (genvar i = 0; i < CW; i++) begin : g_carry
    if (CARRY_TAPS[i]) begin : g_ff
      always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) carry_q[i] <= 1'b0;
        else         carry_q[i] <= carry_d[i];
      end
    end else begin : g_none
      logic unused_cd;
      assign unused_cd  = carry_d[i];
      assign carry_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fcsr_mstep_chk.sv
module fcsr_mstep_chk #(
  parameter int M = 14,
  parameter int D = 8,
  parameter logic [M-2:0] CARRY_TAPS = 13'h0400
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         load,
  input logic         en,
  input logic [M-1:0] seed_main,
  input logic [M-2:0] seed_carry,
  input logic [M-1:0] main_q,
  input logic [M-2:0] carry_q,
  input logic [D-1:0] bits_out
);
  // R5
  load_main_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    load |=> main_q == $past(seed_main));

  // R5 R6
  load_carry_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    load |=> carry_q == ($past(seed_carry) & CARRY_TAPS));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load && !en) |=> ($stable(main_q) && $stable(carry_q)));

  // R8
  top_cell_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (en && !load) |=> main_q[M-1] == $past(bits_out[D-1]));

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    bits_out[0] == main_q[0]);
endmodule

bind fcsr_mstep_gen fcsr_mstep_chk #(.M(M), .D(D), .CARRY_TAPS(CARRY_TAPS)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .load       (load),
  .en         (en),
  .seed_main  (seed_main),
  .seed_carry (seed_carry),
  .main_q     (main_q),
  .carry_q    (carry_q),
  .bits_out   (bits_out)
);

// File: tb/sim_fcsr_mstep_gen.sv
module sim_lane #(
  parameter int M = 4,
  parameter int D = 2,
  parameter logic [M-2:0] TAPS = 3'b001,
  parameter logic [M-1:0] SEED = 4'b0001,
  parameter int CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_err,
  output logic done
);
  logic         load, en;
  logic [M-1:0] seed_main;
  logic [M-2:0] seed_carry;
  logic [D-1:0] bits_out;

  fcsr_mstep_gen #(.M(M), .D(D), .CARRY_TAPS(TAPS), .RESET_SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .seed_main(seed_main),
    .seed_carry(seed_carry), .en(en), .bits_out(bits_out)
  );

  int mx[M];
  int mc[M];

  // R7: one behavioural step of the reference; returns emitted bit
  function automatic int ref_step(ref int x[M], ref int c[M]);
    int f = x[0];
    for (int i = 0; i < M-1; i++) begin
      int s = x[i+1];
      if (TAPS[i]) begin
        s = s + f + c[i];
        c[i] = s / 2;
      end
      x[i] = s % 2;
    end
    x[M-1] = f;
    return f;
  endfunction

  function automatic logic [D-1:0] predict();
    int tx[M];
    int tc[M];
    logic [D-1:0] w;
    tx = mx;
    tc = mc;
    for (int k = 0; k < D; k++) w[k] = ref_step(tx, tc)[0];
    return w;
  endfunction

  task automatic cmp(input string tag);
    logic [D-1:0] exp_w;
    exp_w = predict();
    n_chk++;
    if (bits_out !== exp_w) begin
      n_err++;
      $display("FAIL %s M=%0d D=%0d actual=%b expected=%b", tag, M, D, bits_out, exp_w);
    end
  endtask

  initial begin
    string tag;
    n_chk = 0; n_err = 0; done = 1'b0;
    load = 1'b0; en = 1'b0; seed_main = '0; seed_carry = '0;
    for (int i = 0; i < M; i++) begin
      mx[i] = int'(SEED[i]);
      mc[i] = 0;
    end
    @(posedge rst_n);
    repeat (4) @(negedge clk);
    cmp("R1");
    tag = "R2 R3 R7";
    for (int n = 0; n < CYC; n++) begin
      int r;
      @(negedge clk);
      cmp(tag);
      r = int'($urandom % 100);
      load = 1'b0;
      en   = 1'b0;
      if (r < 4) begin
        load       = 1'b1;
        en         = $urandom % 2 == 0;
        seed_main  = M'($urandom);
        seed_carry = (M-1)'($urandom) | ~TAPS; // R6: untapped ones must be ignored
        for (int i = 0; i < M; i++) mx[i] = int'(seed_main[i]);
        for (int i = 0; i < M-1; i++) mc[i] = TAPS[i] ? int'(seed_carry[i]) : 0;
        tag = "R5 R6";
      end else if (r < 20) begin
        tag = "R4";
      end else begin
        en = 1'b1;
        for (int k = 0; k < D; k++) void'(ref_step(mx, mc));
        tag = "R2 R3 R7";
      end
    end
    @(negedge clk);
    load = 1'b0;
    en   = 1'b0;
    cmp(tag);
    done = 1'b1;
  end
endmodule

module sim_fcsr_mstep_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  localparam int NL = 7;
  int   c_chk [NL];
  int   c_err [NL];
  logic c_done[NL];

  sim_lane #(.M(4), .D(1), .TAPS(3'b001), .SEED(4'b0001)) l0 (clk, rst_n, c_chk[0], c_err[0], c_done[0]);
  sim_lane #(.M(4), .D(2), .TAPS(3'b001), .SEED(4'b0001)) l1 (clk, rst_n, c_chk[1], c_err[1], c_done[1]);
  sim_lane #(.M(4), .D(4), .TAPS(3'b001), .SEED(4'b0110)) l2 (clk, rst_n, c_chk[2], c_err[2], c_done[2]);
  sim_lane #(.M(14), .D(1), .TAPS(13'h0400), .SEED(14'h0001)) l3 (clk, rst_n, c_chk[3], c_err[3], c_done[3]);
  sim_lane #(.M(14), .D(2), .TAPS(13'h0400), .SEED(14'h2A51)) l4 (clk, rst_n, c_chk[4], c_err[4], c_done[4]);
  sim_lane #(.M(14), .D(4), .TAPS(13'h0400), .SEED(14'h0001)) l5 (clk, rst_n, c_chk[5], c_err[5], c_done[5]);
  sim_lane #(.M(14), .D(8), .TAPS(13'h0400), .SEED(14'h0001)) l6 (clk, rst_n, c_chk[6], c_err[6], c_done[6]);

  initial begin
    int checks;
    int errors;
    int cyc;
    bit all_done;
    checks = 0; errors = 0; cyc = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    all_done = 1'b0;
    while (!all_done && cyc < 100000) begin
      @(negedge clk);
      cyc++;
      all_done = 1'b1;
      for (int i = 0; i < NL; i++) if (c_done[i] !== 1'b1) all_done = 1'b0;
    end
    for (int i = 0; i < NL; i++) begin
      checks += c_chk[i];
      errors += c_err[i];
    end
    if (!all_done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=hung expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule